// File: doc/BRIEF.md
# I2C Clock Phase Generator

This block produces the clock line of an I2C master. It alternates between a low phase and a high phase. Each phase lasts a programmed number of ticks. One tick is one or two input clocks, chosen by a select input. The block pulls SCL low through an open-drain enable and watches the line it releases. A slave that holds SCL low therefore lengthens the cycle rather than shortening the high phase.

Each count is nine bits wide. The low eight bits come from their own byte inputs. The ninth bits come from two control bits, which the register map places at positions 7 (low count) and 6 (high count) of the interrupt-control register. A build parameter can restrict both counts to eight bits. Typical counts equal the tick rate times the nominal phase time, plus 0.3 µs of fall time, rounded to the nearest tick. For standard mode the nominal times are 4.7 µs low and 4.0 µs high; for fast mode they are 1.3 µs and 0.6 µs.

A byte engine drives the run input. It uses the two strobes to change SDA in the middle of the low phase and to sample SDA at the start of the high phase. A watchdog flag reports a slave that stretches the clock for too long.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset SCL is released and the strobes and the stretch flag are all low.
- R2: With WIDE_CNT=1, the low count is {cnt_msb[1], low_byte} and the high count is {cnt_msb[0], high_byte}.
- R3: With WIDE_CNT=0, cnt_msb has no effect, so both counts are at most 0xFF.
- R4: The low phase starts on the first cycle SCL is driven low and lasts count*D cycles. D is 1 when div2=0 and 2 when div2=1.
- R5: A count of zero behaves exactly like a count of one.
- R6: After release, the high phase begins one cycle after the first cycle in which scl_in is seen high. It lasts count*D cycles, and then the next low phase follows while run is held.
- R7: sda_change_stb pulses exactly once per low phase, at low-phase cycle floor(count/2)*D, counting from 0.
- R8: sda_sample_stb pulses exactly once per high phase, on its first cycle, and only while SCL is released.
- R9: While SCL is released but still held low externally, the high count does not advance. Once scl_in has stayed low for more than stretch_limit cycles, stretch_timeout rises, at release cycle stretch_limit+1. It falls before the high phase begins.
- R10: From idle, the low phase starts on the cycle after run is seen high. If run is dropped, the current period still finishes through its high phase, and SCL then stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Keep generating clock periods |
| low_byte | input | BYTE_W | Low-phase count, lower bits |
| high_byte | input | BYTE_W | High-phase count, lower bits |
| cnt_msb | input | 2 | Top count bits: [1] low, [0] high |
| div2 | input | 1 | 1: two input clocks per tick |
| stretch_limit | input | WD_W | Stretch watchdog limit in cycles |
| scl_in | input | 1 | Synchronized SCL line level |
| scl_drive_low | output | 1 | Open-drain pull-down enable for SCL |
| sda_change_stb | output | 1 | Mid-low pulse: SDA may change |
| sda_sample_stb | output | 1 | Start-of-high pulse: sample SDA |
| stretch_timeout | output | 1 | SCL held low too long after release |

## Verification
The assertions check the local rules on every cycle. The change strobe appears only while SCL is driven low. The sample strobe follows a cycle in which the line was seen high, and it lasts one cycle. The phase count is frozen while the release is being stretched. Idle persists without run, and the timeout flag never coexists with a driven-low line.

Only the bench scenarios can show the exact phase lengths, the strobe positions and the cycle on which the stretch flag rises. These depend on the programmed counts, the ninth-bit and narrow builds, the zero-count case and the controlled stop. The bench covers them with directed boundaries and seeded random configurations.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } scl_state_e;
endpackage

// File: rtl/scl_tick_prescale.sv
`timescale 1ns/1ps
// Tick generator: one tick per clock, or one per two clocks.
// It restarts at every phase entry so each phase holds whole ticks.
module scl_tick_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic div2,
  output logic tick,
  output logic head
);
  logic pre_q;
  logic pre_d;

  always_comb begin
    if (restart) pre_d = 1'b0;
    else         pre_d = div2 & ~pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= 1'b0;
    else        pre_q <= pre_d;
  end

  assign tick = ~div2 | pre_q;
  assign head = ~pre_q;
endmodule

// File: rtl/scl_phase_counter.sv
`timescale 1ns/1ps
// Tick counter for the current phase; last marks the final tick.
module scl_phase_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  input  logic [CNT_W-1:0] span,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)      cnt_d = '0;
    else if (advance) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == span - 1'b1);
endmodule

// File: rtl/scl_stretch_watch.sv
`timescale 1ns/1ps
// Counts how long SCL stays low after release and flags overlong stretching.
module scl_stretch_watch #(
  parameter int WD_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            watching,
  input  logic            scl_in,
  input  logic [WD_W-1:0] limit,
  output logic            timeout
);
  logic [WD_W-1:0] wd_q;
  logic [WD_W-1:0] wd_d;
  logic            flag_q;
  logic            flag_d;
  logic            held_low;

  assign held_low = watching & ~scl_in;

  always_comb begin
    wd_d   = '0;
    flag_d = 1'b0;
    if (held_low) begin
      flag_d = (wd_q == limit);
      if (wd_q != limit) wd_d = wd_q + 1'b1;
      else               wd_d = wd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      wd_q   <= wd_d;
      flag_q <= flag_d;
    end
  end

  assign timeout = flag_q;
endmodule

// File: rtl/scl_count_select.sv
`timescale 1ns/1ps
// Builds the effective phase count. The top bit is masked in the narrow
// build, and a zero count is replaced by one.
module scl_count_select #(
  parameter int BYTE_W = 8,
  parameter bit WIDE   = 1'b1
) (
  input  logic [BYTE_W-1:0] base,
  input  logic              ext_bit,
  output logic [BYTE_W:0]   eff
);
  logic [BYTE_W:0] raw;

  assign raw = {ext_bit & WIDE, base};

  always_comb begin
    if (raw == '0) eff = {{BYTE_W{1'b0}}, 1'b1};
    else           eff = raw;
  end
endmodule

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter bit WIDE_CNT = 1'b1,
  parameter int BYTE_W   = 8,
  parameter int WD_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [BYTE_W-1:0] low_byte,
  input  logic [BYTE_W-1:0] high_byte,
  input  logic [1:0]        cnt_msb,
  input  logic              div2,
  input  logic [WD_W-1:0]   stretch_limit,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              sda_change_stb,
  output logic              sda_sample_stb,
  output logic              stretch_timeout
);
  localparam int CNT_W   = BYTE_W + 1;
  localparam int LOW_MSB = 1;
  localparam int HI_MSB  = 0;

  scl_state_e       state_q;
  scl_state_e       state_d;
  logic [CNT_W-1:0] low_eff;
  logic [CNT_W-1:0] high_eff;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] cnt_q;
  logic             restart;
  logic             tick;
  logic             head;
  logic             last;
  logic             in_phase;
  logic             done;

  scl_count_select #(.BYTE_W(BYTE_W), .WIDE(WIDE_CNT)) u_low_sel (
    .base(low_byte), .ext_bit(cnt_msb[LOW_MSB]), .eff(low_eff)
  );

  scl_count_select #(.BYTE_W(BYTE_W), .WIDE(WIDE_CNT)) u_high_sel (
    .base(high_byte), .ext_bit(cnt_msb[HI_MSB]), .eff(high_eff)
  );

  assign span     = (state_q == ST_HIGH) ? high_eff : low_eff;
  assign in_phase = (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign restart  = (state_d != state_q);

  scl_tick_prescale u_prescale (
    .clk(clk), .rst_n(rst_n), .restart(restart), .div2(div2),
    .tick(tick), .head(head)
  );

  scl_phase_counter #(.CNT_W(CNT_W)) u_phase_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart),
    .advance(in_phase & tick), .span(span),
    .cnt(cnt_q), .last(last)
  );

  scl_stretch_watch #(.WD_W(WD_W)) u_stretch (
    .clk(clk), .rst_n(rst_n), .watching(state_q == ST_WAIT),
    .scl_in(scl_in), .limit(stretch_limit), .timeout(stretch_timeout)
  );

  assign done = last & tick;

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (run)    state_d = ST_LOW;
      ST_LOW:  if (done)   state_d = ST_WAIT;
      ST_WAIT: if (scl_in) state_d = ST_HIGH;
      ST_HIGH: if (done)   state_d = run ? ST_LOW : ST_IDLE;
      default:             state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign scl_drive_low  = (state_q == ST_LOW);
  assign sda_change_stb = (state_q == ST_LOW)  && head && (cnt_q == (low_eff >> 1));
  assign sda_sample_stb = (state_q == ST_HIGH) && head && (cnt_q == '0);
endmodule

// File: rtl/scl_timing_gen_chk.sv
`timescale 1ns/1ps
module scl_timing_gen_chk
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             scl_in,
  input logic             div2,
  input logic             scl_drive_low,
  input logic             sda_change_stb,
  input logic             sda_sample_stb,
  input logic             stretch_timeout,
  input scl_state_e       state_q,
  input logic [CNT_W-1:0] cnt_q
);
  assert_change_in_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_change_stb |-> scl_drive_low);

  assert_sample_after_seen_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample_stb |-> ($past(scl_in) && !scl_drive_low));

  assert_sample_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sda_sample_stb |=> !sda_sample_stb);

  assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sda_change_stb, sda_sample_stb, stretch_timeout}));

  assert_flag_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_timeout |-> !scl_drive_low);

  assert_count_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (cnt_q == '0));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !run) |=> (state_q == ST_IDLE && !scl_drive_low));

  assert_min_low_div2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_drive_low) && div2) |=> scl_drive_low);
endmodule

bind scl_timing_gen scl_timing_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .scl_in(scl_in), .div2(div2),
  .scl_drive_low(scl_drive_low), .sda_change_stb(sda_change_stb),
  .sda_sample_stb(sda_sample_stb), .stretch_timeout(stretch_timeout),
  .state_q(state_q), .cnt_q(cnt_q)
);

// File: tb/test_scl_timing_gen.sv
`timescale 1ns/1ps
module test_scl_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_w = 1'b0;
  logic        run_n = 1'b0;
  logic [7:0]  cfg_lo = '0;
  logic [7:0]  cfg_hi = '0;
  logic [1:0]  cfg_msb = '0;
  logic        cfg_div2 = 1'b0;
  logic [11:0] cfg_lim = '0;
  logic        hold = 1'b0;
  logic        use_n = 1'b0;
  logic        w_drv, w_chg, w_smp, w_flag, w_scl;
  logic        n_drv, n_chg, n_smp, n_flag, n_scl;
  logic        o_drv, o_chg, o_smp, o_flag;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  assign w_scl  = ~(w_drv | hold);
  assign n_scl  = ~(n_drv | hold);
  assign o_drv  = use_n ? n_drv  : w_drv;
  assign o_chg  = use_n ? n_chg  : w_chg;
  assign o_smp  = use_n ? n_smp  : w_smp;
  assign o_flag = use_n ? n_flag : w_flag;

  scl_timing_gen i_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .run(run_w), .low_byte(cfg_lo), .high_byte(cfg_hi),
    .cnt_msb(cfg_msb), .div2(cfg_div2), .stretch_limit(cfg_lim), .scl_in(w_scl),
    .scl_drive_low(w_drv), .sda_change_stb(w_chg), .sda_sample_stb(w_smp),
    .stretch_timeout(w_flag)
  );

  scl_timing_gen #(.WIDE_CNT(1'b0)) i_scl_timing_gen_narrow (
    .clk(clk), .rst_n(rst_n), .run(run_n), .low_byte(cfg_lo), .high_byte(cfg_hi),
    .cnt_msb(cfg_msb), .div2(cfg_div2), .stretch_limit(cfg_lim), .scl_in(n_scl),
    .scl_drive_low(n_drv), .sda_change_stb(n_chg), .sda_sample_stb(n_smp),
    .stretch_timeout(n_flag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_count(input int v, input bit narrow);
    int e;
    e = narrow ? (v & 255) : (v & 511);
    return (e == 0) ? 1 : e;
  endfunction

  function automatic int exp_flag_at(input int hold_n, input int lim);
    return (hold_n >= lim + 1) ? lim + 1 : -1;
  endfunction

  task automatic run_case(input string tag, input bit narrow, input int lo9, input int hi9,
                          input bit d2, input int hold_n, input int lim);
    int el, eh, dv, guard, low_n, mid_at, mids, rel, flag_at, flag_smp, hi_n, smps;
    int tail, win_low, win_smp;
    el = eff_count(lo9, narrow);
    eh = eff_count(hi9, narrow);
    dv = d2 ? 2 : 1;
    @(negedge clk);
    use_n    = narrow;
    cfg_lo   = 8'(lo9);
    cfg_hi   = 8'(hi9);
    cfg_msb  = {1'((lo9 >> 8) & 1), 1'((hi9 >> 8) & 1)};
    cfg_div2 = d2;
    cfg_lim  = 12'(lim);
    hold     = 1'b0;
    if (narrow) run_n = 1'b1; else run_w = 1'b1;
    @(negedge clk);
    guard = 0;
    while (!o_drv && guard < 8) begin guard++; @(negedge clk); end
    chk("R10", {tag, " low starts after run"}, guard, 0);
    // low phase
    low_n = 0; mid_at = -1; mids = 0;
    while (o_drv && low_n < 5000) begin
      if (o_chg) begin mids++; if (mid_at < 0) mid_at = low_n; end
      low_n++;
      @(negedge clk);
    end
    // release, optionally stretched by the slave model
    rel = 0; flag_at = -1;
    while (!o_smp && rel < 5000) begin
      if (o_flag && flag_at < 0) flag_at = rel;
      hold = (rel < hold_n);
      rel++;
      @(negedge clk);
    end
    hold = 1'b0;
    flag_smp = int'(o_flag);
    // high phase
    hi_n = 0; smps = 0;
    while (!o_drv && hi_n < 5000) begin
      if (o_smp) smps++;
      hi_n++;
      @(negedge clk);
    end
    // stop request during the next low phase
    run_w = 1'b0; run_n = 1'b0;
    tail = 0;
    while (o_drv && tail < 5000) begin tail++; @(negedge clk); end
    win_low = 0; win_smp = 0;
    repeat (eh * dv + 45) begin
      if (o_drv) win_low++;
      if (o_smp) win_smp++;
      @(negedge clk);
    end
    chk(tag, "low length", low_n, el * dv);
    chk("R7", {tag, " change strobe position"}, mid_at, (el >> 1) * dv);
    chk("R7", {tag, " change strobes per low"}, mids, 1);
    chk("R6", {tag, " release to high"}, rel, hold_n + 1);
    chk("R9", {tag, " flag first cycle"}, flag_at, exp_flag_at(hold_n, lim));
    chk("R9", {tag, " flag at high start"}, flag_smp, 0);
    chk("R6", {tag, " high length"}, hi_n, eh * dv);
    chk("R8", {tag, " sample strobes per high"}, smps, 1);
    chk("R10", {tag, " last low completes"}, tail, el * dv);
    chk("R10", {tag, " no low after stop"}, win_low, 0);
    chk("R10", {tag, " final high completes"}, win_smp, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "wide drive", int'(w_drv), 0);
    chk("R1", "wide strobes", int'(w_chg | w_smp), 0);
    chk("R1", "wide flag", int'(w_flag), 0);
    chk("R1", "narrow outputs", int'(n_drv | n_chg | n_smp | n_flag), 0);
    begin
      int lows;
      lows = 0;
      repeat (20) begin if (w_drv | n_drv) lows++; @(negedge clk); end
      chk("R10", "idle without run", lows, 0);
    end
    run_case("R4", 1'b0, 5, 4, 1'b0, 0, 3);
    run_case("R4", 1'b0, 5, 4, 1'b1, 0, 3);
    run_case("R4", 1'b0, 1, 1, 1'b1, 0, 0);
    run_case("R5", 1'b0, 0, 0, 1'b0, 0, 2);
    run_case("R5", 1'b0, 0, 0, 1'b1, 0, 2);
    run_case("R2", 1'b0, 'h105, 'h102, 1'b0, 0, 4);
    run_case("R2", 1'b0, 'h100, 'h003, 1'b1, 1, 4);
    run_case("R3", 1'b1, 'h105, 'h102, 1'b0, 0, 4);
    run_case("R3", 1'b1, 'h100, 'h1ff, 1'b0, 0, 4);
    run_case("R9", 1'b0, 6, 3, 1'b0, 8, 2);
    run_case("R9", 1'b0, 6, 3, 1'b0, 3, 3);
    run_case("R9", 1'b0, 6, 3, 1'b1, 4, 3);
    run_case("R9", 1'b0, 2, 2, 1'b0, 1, 0);
    for (int i = 0; i < 16; i++) begin
      int lo, hi, hl, lm;
      bit nr, d2;
      lo = int'($urandom_range(0, 40));
      hi = int'($urandom_range(0, 40));
      if ($urandom_range(0, 3) == 0) lo += 256;
      if ($urandom_range(0, 3) == 0) hi += 256;
      nr = 1'($urandom_range(0, 1));
      d2 = 1'($urandom_range(0, 1));
      hl = int'($urandom_range(0, 7));
      lm = int'($urandom_range(0, 5));
      run_case(nr ? "R3" : "R4", nr, lo, hi, d2, hl, lm);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule